// File: doc/BRIEF.md
# Interrupt Status and Signalling Unit

This block keeps a 32-bit word of pending interrupt causes and tells the host about them. Two internal engines report completion through single-cycle event inputs: a calculation engine sets bit 0 and a copy engine sets bit 8. Software can also set any bit through a raise port and clear any bit through a lower port. Each port takes a mask: a one in the mask sets or clears that bit, and a zero leaves it alone. The current word is always visible on a read output.

A mode input selects how the host is told. In legacy mode the block drives a level-sensitive line. The line goes high when a raise leaves the word non-zero. It goes low only when a lower leaves the word empty. In message mode the line stays low and the block instead emits a one-cycle pulse for every raise that leaves the word non-zero, even when bits were already pending. Building and delivering the messages belongs to the logic around this block.

Top module: `intr_flag_hub`

## Requirements
- R1: After reset the status word is zero, the level line is low and the message pulse is low.
- R2: A raise write ORs its data into the status word, and the result is visible on the cycle after the write.
- R3: A lower write clears every status bit whose data bit is one. All other bits keep their value.
- R4: Raise writes and engine events in the same cycle are merged by OR. When a bit is raised and lowered in the same cycle, it ends up set.
- R5: A calculation-done event sets status bit 0 and a copy-done event sets status bit 8. Each event counts as a raise.
- R6: In legacy mode (mode input 0), a raise that leaves the word non-zero drives the level line high on the next cycle. A raise that leaves the word zero does not change the line.
- R7: In legacy mode, a lower drives the line low only when it leaves the word zero. Otherwise the line does not change. While the line is high, the word is never zero.
- R8: In message mode (mode input 1), every raise that leaves the word non-zero gives exactly one pulse cycle, on the next cycle, even if the word was already non-zero. Legacy mode never pulses.
- R9: While message mode is set, the level line is low from the next cycle onward. Changing the mode alters no status bit. A lower never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| calc_done | input | 1 | Calculation engine completion event (bit 0) |
| copy_done | input | 1 | Copy engine completion event (bit 8) |
| raise_we | input | 1 | Write strobe for the raise port |
| raise_data | input | 32 | Mask of bits to set |
| lower_we | input | 1 | Write strobe for the lower port |
| lower_data | input | 32 | Mask of bits to clear |
| status_rd | output | 32 | Current interrupt-status word |
| level_irq | output | 1 | Legacy level-sensitive interrupt line |
| msg_pulse | output | 1 | One-cycle message request |

## Verification
The hardest cases to reach are those where several things happen in one cycle. A raise can arrive together with a lower of the same bit, together with engine events, and while the mode is changing. Each of these decides both the stored word and the two signalling outputs. The stimulus first walks through a directed sequence: set, partial clear, full clear, empty raise, colliding raise and lower, and a mode switch that leaves bits pending. It then runs a long pseudo-random sweep. In the sweep the clear masks are sometimes all ones, so the word often returns to zero. The engine events come rarely, and the mode flips every 64 cycles. Every cycle is compared against an arithmetic model kept in the bench.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;
  typedef enum logic {
    SIG_LEVEL = 1'b0,
    SIG_MSG   = 1'b1
  } sig_mode_e;

  localparam int unsigned DEF_WIDTH    = 32;
  localparam int unsigned DEF_CALC_BIT = 0;
  localparam int unsigned DEF_COPY_BIT = 8;
endpackage

// File: rtl/intr_status_reg.sv
module intr_status_reg #(
  parameter int unsigned WIDTH    = intr_hub_pkg::DEF_WIDTH,
  parameter int unsigned CALC_BIT = intr_hub_pkg::DEF_CALC_BIT,
  parameter int unsigned COPY_BIT = intr_hub_pkg::DEF_COPY_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             calc_done,
  input  logic             copy_done,
  input  logic             raise_we,
  input  logic [WIDTH-1:0] raise_data,
  input  logic             lower_we,
  input  logic [WIDTH-1:0] lower_data,
  output logic [WIDTH-1:0] status_q,
  output logic             raise_evt,
  output logic             lower_evt,
  output logic             next_nonzero
);
  // a set bit always wins over a clear of the same bit
  function automatic logic [WIDTH-1:0] merge_word(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] set_m,
    input logic [WIDTH-1:0] clr_m
  );
    return (cur & ~clr_m) | set_m;
  endfunction

  logic [WIDTH-1:0] engine_mask;
  logic [WIDTH-1:0] set_mask;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] status_d;

  for (genvar b = 0; b < WIDTH; b++) begin : g_engine_map
    assign engine_mask[b] = ((b == CALC_BIT) && calc_done) ||
                            ((b == COPY_BIT) && copy_done);
  end

  assign set_mask     = engine_mask | (raise_we ? raise_data : '0);
  assign clr_mask     = lower_we ? lower_data : '0;
  assign status_d     = merge_word(status_q, set_mask, clr_mask);
  assign raise_evt    = raise_we | calc_done | copy_done;
  assign lower_evt    = lower_we;
  assign next_nonzero = |status_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/intr_signal_gen.sv
module intr_signal_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic msg_mode,
  input  logic raise_evt,
  input  logic lower_evt,
  input  logic next_nonzero,
  output logic level_q,
  output logic pulse_q
);
  import intr_hub_pkg::*;

  sig_mode_e mode;
  logic      fire;
  logic      drop;
  logic      level_d;

  assign mode = sig_mode_e'(msg_mode);
  assign fire = raise_evt & next_nonzero;
  assign drop = lower_evt & ~next_nonzero;

  always_comb begin
    level_d = level_q;
    if (mode == SIG_MSG) level_d = 1'b0;
    else if (fire)       level_d = 1'b1;
    else if (drop)       level_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= level_d;
      pulse_q <= (mode == SIG_MSG) & fire;
    end
  end
endmodule

// File: rtl/intr_flag_hub.sv
module intr_flag_hub #(
  parameter int unsigned WIDTH    = intr_hub_pkg::DEF_WIDTH,
  parameter int unsigned CALC_BIT = intr_hub_pkg::DEF_CALC_BIT,
  parameter int unsigned COPY_BIT = intr_hub_pkg::DEF_COPY_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode,
  input  logic             calc_done,
  input  logic             copy_done,
  input  logic             raise_we,
  input  logic [WIDTH-1:0] raise_data,
  input  logic             lower_we,
  input  logic [WIDTH-1:0] lower_data,
  output logic [WIDTH-1:0] status_rd,
  output logic             level_irq,
  output logic             msg_pulse
);
  logic raise_evt;
  logic lower_evt;
  logic next_nonzero;

  intr_status_reg #(
    .WIDTH(WIDTH), .CALC_BIT(CALC_BIT), .COPY_BIT(COPY_BIT)
  ) u_status (
    .clk(clk), .rst_n(rst_n),
    .calc_done(calc_done), .copy_done(copy_done),
    .raise_we(raise_we), .raise_data(raise_data),
    .lower_we(lower_we), .lower_data(lower_data),
    .status_q(status_rd),
    .raise_evt(raise_evt), .lower_evt(lower_evt),
    .next_nonzero(next_nonzero)
  );

  intr_signal_gen u_signal (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
    .raise_evt(raise_evt), .lower_evt(lower_evt),
    .next_nonzero(next_nonzero),
    .level_q(level_irq), .pulse_q(msg_pulse)
  );
endmodule

// File: rtl/intr_flag_hub_chk.sv
module intr_flag_hub_chk #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned CALC_BIT = 0,
  parameter int unsigned COPY_BIT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_mode,
  input logic             calc_done,
  input logic             copy_done,
  input logic             raise_we,
  input logic [WIDTH-1:0] raise_data,
  input logic             lower_we,
  input logic [WIDTH-1:0] lower_data,
  input logic [WIDTH-1:0] status_rd,
  input logic             level_irq,
  input logic             msg_pulse
);
  p_raise_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_we |=> ((status_rd & $past(raise_data)) == $past(raise_data)));

  p_lower_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_we && !raise_we && !calc_done && !copy_done)
      |=> ((status_rd & $past(lower_data)) == '0));

  p_calc_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done |=> status_rd[CALC_BIT]);

  p_copy_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> status_rd[COPY_BIT]);

  p_line_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level_irq |-> (status_rd != '0));

  p_pulse_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> (status_rd != '0));

  p_legacy_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> !msg_pulse);

  p_msg_quiets_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> !level_irq);

  p_lower_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_we && !raise_we && !calc_done && !copy_done) |=> !msg_pulse);
endmodule

bind intr_flag_hub intr_flag_hub_chk #(
  .WIDTH(WIDTH), .CALC_BIT(CALC_BIT), .COPY_BIT(COPY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
  .calc_done(calc_done), .copy_done(copy_done),
  .raise_we(raise_we), .raise_data(raise_data),
  .lower_we(lower_we), .lower_data(lower_data),
  .status_rd(status_rd), .level_irq(level_irq), .msg_pulse(msg_pulse)
);

// File: tb/test_intr_flag_hub.sv
module test_intr_flag_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_mode = 1'b0;
  logic        calc_done = 1'b0;
  logic        copy_done = 1'b0;
  logic        raise_we = 1'b0;
  logic [31:0] raise_data = '0;
  logic        lower_we = 1'b0;
  logic [31:0] lower_data = '0;
  logic [31:0] status_rd;
  logic        level_irq;
  logic        msg_pulse;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_status = '0;
  logic        m_level = 1'b0;
  logic        m_pulse = 1'b0;

  always #5 clk = ~clk;

  intr_flag_hub i_intr_flag_hub (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
    .calc_done(calc_done), .copy_done(copy_done),
    .raise_we(raise_we), .raise_data(raise_data),
    .lower_we(lower_we), .lower_data(lower_data),
    .status_rd(status_rd), .level_irq(level_irq), .msg_pulse(msg_pulse)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // model computed from the requirements, then one clock, then compare
  task automatic step(input logic rw, input logic [31:0] rd,
                      input logic lw, input logic [31:0] ld,
                      input logic cd, input logic pd, input logic md,
                      input string tag);
    logic [31:0] setm;
    logic [31:0] nxt;
    logic        ev;
    raise_we = rw; raise_data = rd; lower_we = lw; lower_data = ld;
    calc_done = cd; copy_done = pd; msg_mode = md;
    setm = (rw ? rd : 32'h0) | {31'h0, cd} | (pd ? 32'h100 : 32'h0);
    nxt  = 32'h0;
    for (int b = 0; b < 32; b++)
      nxt[b] = setm[b] | (m_status[b] & ~(lw & ld[b]));
    ev = rw | cd | pd;
    m_pulse = md && ev && (nxt != 0);
    if (md) m_level = 1'b0;
    else if (ev && nxt != 0) m_level = 1'b1;
    else if (lw && nxt == 0) m_level = 1'b0;
    m_status = nxt;
    @(posedge clk);
    #1;
    check(tag, "status", status_rd, m_status);
    check(tag, "level", {31'h0, level_irq}, {31'h0, m_level});
    check(tag, "pulse", {31'h0, msg_pulse}, {31'h0, m_pulse});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "status", status_rd, 32'h0);
    check("R1", "level", {31'h0, level_irq}, 32'h0);
    check("R1", "pulse", {31'h0, msg_pulse}, 32'h0);
    rst_n = 1'b1;

    step(1, 32'h5, 0, 0, 0, 0, 0, "R2");          // set, line high
    step(0, 0, 1, 32'h1, 0, 0, 0, "R7");          // partial clear keeps line
    step(0, 0, 1, 32'h4, 0, 0, 0, "R3");          // empty -> line low
    step(1, 32'h0, 0, 0, 0, 0, 0, "R6");          // empty raise, line stays low
    step(1, 32'h3, 1, 32'h1, 0, 0, 0, "R4");      // collide: bit 0 kept
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, "R3");
    step(1, 32'h10, 0, 0, 1, 1, 0, "R5");         // 0x111 merged
    step(0, 0, 0, 0, 0, 0, 1, "R9");              // mode switch: bits kept, line low
    step(1, 32'h2, 0, 0, 0, 0, 1, "R8");          // pulse
    step(0, 0, 0, 0, 0, 0, 1, "R8");              // single cycle
    step(1, 32'h2, 0, 0, 0, 0, 1, "R8");          // already set, pulses again
    step(0, 0, 0, 0, 1, 0, 1, "R5");              // engine event pulses
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 1, "R9");  // lower: no pulse
    step(1, 32'h0, 0, 0, 0, 0, 1, "R8");          // empty raise: no pulse
    step(1, 32'h8000_0000, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, "R6");

    r = 32'h1D87_2B41;
    for (int i = 0; i < 3000; i++) begin
      r = {r[30:0], 1'b0} ^ (r[31] ? 32'h04C1_1DB7 : 32'h0);
      step(r[0] & r[1], (32'h1 << r[6:2]) | (r[21] ? 32'h0 : 32'h2),
           r[13] | r[14], r[7] ? 32'hFFFF_FFFF : (32'h1 << r[12:8]),
           r[15] & r[16] & r[17], r[18] & r[19] & r[20],
           i[6], i[6] ? "R8" : "R6");
    end
    finish_run();
  end
endmodule